// File: doc/BRIEF.md
# Peripheral protection configuration bank

This block holds the security configuration for ten peripheral protection controllers: two internal APB controllers, four APB expansion controllers and four AHB expansion controllers. Each controller keeps three per-port masks. The first is a non-secure select. The second is an access mask used when the port is secure. The third is an access mask used when the port is non-secure. Software programs these masks through two 32-bit register windows. The secure window reaches the non-secure selects and the secure-side access masks. The non-secure window reaches only the non-secure-side access masks.

For every port the bank drives two signals. One is a non-secure indication, copied from the stored select bit. The other is an access-permission level, taken from one of the two access masks according to that port's select bit. Each window is a simple one-cycle register port. A write strobe with address, size and data is captured on the rising clock edge. Read data is a combinational function of the window's address and size. An access never stalls and never reports an error.

Top module: `ppc_cfg_bank`

## Requirements
- R1: For every port, `portAccess` equals the non-secure-side access bit when that port's non-secure select bit is 1, and the secure-side access bit when it is 0.
- R2: Each bit of `portNonSec` equals the stored non-secure select bit of the same port.
- R3: A written value is cut to the controller's port count before it is stored. The defaults are 4 ports for internal APB controller 0, 1 port for internal APB controller 1 and 16 ports for each expansion controller. Bits at and above that count read back as 0 and drive 0 on both port outputs.
- R4: Within a group, address bits [3:2] select the controller. In the secure window the non-secure selects sit at 0x70/0x74 (internal APB 0–1), 0x80–0x8C (APB expansion 0–3) and 0x60–0x6C (AHB expansion 0–3). The secure-side access masks sit at 0xB0/0xB4, 0xC0–0xCC and 0xA0–0xAC for the same controllers. Port p of controller c appears at output bit c×MAX_PORTS+p, with c numbered as internal APB 0–1, then APB expansion 0–3, then AHB expansion 0–3.
- R5: The non-secure window writes the non-secure-side access masks at 0xB0/0xB4, 0xC0–0xCC and 0xA0–0xAC, and it can change nothing else. A secure-window write never changes a non-secure-side access mask.
- R6: A write takes effect only when the size code is 2 (32 bits) and the address bits [1:0] are 0. Size codes 0 (byte) and 1 (halfword), and misaligned word writes, change no state.
- R7: A read with size code 0 returns the register's byte at bit offset addr[1:0]×8, zero-extended. Size code 1 returns the 16 bits starting at that offset, zero-extended. Size code 2 returns the full 32-bit register.
- R8: Offsets 0x50 and 0x90 of the secure window, offset 0x90 of the non-secure window, and every unmapped offset read as 0. Writes to them change no state.
- R9: While `rstN` is low, and after reset is released, every mask is 0. Every read and both port outputs are then 0.
- R10: An accepted write is visible on the port outputs and in read data from the first rising clock edge at which the write strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secWrEn | input | 1 | Secure-window write strobe |
| secAddr | input | ADDR_W (12) | Secure-window byte address |
| secSize | input | 2 | Secure-window access size: 0 byte, 1 halfword, 2 word |
| secWdata | input | 32 | Secure-window write data |
| secRdata | output | 32 | Secure-window read data |
| nsWrEn | input | 1 | Non-secure-window write strobe |
| nsAddr | input | ADDR_W (12) | Non-secure-window byte address |
| nsSize | input | 2 | Non-secure-window access size: 0 byte, 1 halfword, 2 word |
| nsWdata | input | 32 | Non-secure-window write data |
| nsRdata | output | 32 | Non-secure-window read data |
| portNonSec | output | NUM_CTRL×MAX_PORTS (160) | Per-port non-secure indication |
| portAccess | output | NUM_CTRL×MAX_PORTS (160) | Per-port access-permission level |

## Verification
The assertions assume that the window inputs are known, with no X or Z, whenever `rstN` is high. They also assume that a write strobe and its address, size and data are held steady across the whole cycle up to the sampling edge. The stability properties treat any edge without a qualifying strobe as one that leaves the masks unchanged. The bench changes every input only at the falling edge and drives nothing while reset is low. It uses only the size codes 0, 1 and 2. Its random addresses come from the mapped, reserved and unmapped offsets, each with random low address bits, so both the qualifying and the rejected cases of every decode are exercised.

// File: rtl/ppc_cfg_pkg.sv
package ppc_cfg_pkg;

  // controller layout: internal APB, then APB expansion, then AHB expansion
  localparam int N_APB_INT  = 2;
  localparam int N_APB_EXP  = 4;
  localparam int N_AHB_EXP  = 4;
  localparam int NUM_CTRL   = N_APB_INT + N_APB_EXP + N_AHB_EXP;
  localparam int CTRL_W     = $clog2(NUM_CTRL);
  localparam int APBX_BASE  = N_APB_INT;
  localparam int AHBX_BASE  = N_APB_INT + N_APB_EXP;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    KIND_NS   = 2'd0,
    KIND_SP   = 2'd1,
    KIND_NSP  = 2'd2,
    KIND_NONE = 2'd3
  } cfgKind_e;

  typedef struct packed {
    logic              en;
    cfgKind_e          kind;
    logic [CTRL_W-1:0] ctrl;
  } cfgSel_t;

  typedef struct packed {
    cfgSel_t sWr;
    cfgSel_t nsWr;
    cfgSel_t sRd;
    cfgSel_t nsRd;
  } cfgStrobe_t;

endpackage

// File: rtl/ppc_cfg_ctrl.sv
module ppc_cfg_ctrl
  import ppc_cfg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secWrEn,
  input  logic [ADDR_W-1:0] secAddr,
  input  logic [1:0]        secSize,
  input  logic              nsWrEn,
  input  logic [ADDR_W-1:0] nsAddr,
  input  logic [1:0]        nsSize,
  output cfgStrobe_t        strobe
);

  localparam int GRP_W = ADDR_W - 4;

  // group codes: address bits above the 16-byte group
  localparam logic [GRP_W-1:0] G_AHBX_NS = GRP_W'(6);
  localparam logic [GRP_W-1:0] G_APBI_NS = GRP_W'(7);
  localparam logic [GRP_W-1:0] G_APBX_NS = GRP_W'(8);
  localparam logic [GRP_W-1:0] G_AHBX_PR = GRP_W'(10);
  localparam logic [GRP_W-1:0] G_APBI_PR = GRP_W'(11);
  localparam logic [GRP_W-1:0] G_APBX_PR = GRP_W'(12);

  function automatic cfgSel_t decode(input logic secure, input logic [ADDR_W-1:0] a);
    cfgSel_t          sel;
    logic [GRP_W-1:0] grp;
    logic [1:0]       slot;
    cfgKind_e         prKind;
    grp    = a[ADDR_W-1:4];
    slot   = a[3:2];
    prKind = secure ? KIND_SP : KIND_NSP;
    sel    = '{en: 1'b0, kind: KIND_NONE, ctrl: '0};
    if (secure && grp == G_AHBX_NS) begin
      sel = '{en: 1'b1, kind: KIND_NS, ctrl: CTRL_W'(AHBX_BASE) + CTRL_W'(slot)};
    end else if (secure && grp == G_APBI_NS && int'(slot) < N_APB_INT) begin
      sel = '{en: 1'b1, kind: KIND_NS, ctrl: CTRL_W'(slot)};
    end else if (secure && grp == G_APBX_NS) begin
      sel = '{en: 1'b1, kind: KIND_NS, ctrl: CTRL_W'(APBX_BASE) + CTRL_W'(slot)};
    end else if (grp == G_AHBX_PR) begin
      sel = '{en: 1'b1, kind: prKind, ctrl: CTRL_W'(AHBX_BASE) + CTRL_W'(slot)};
    end else if (grp == G_APBI_PR && int'(slot) < N_APB_INT) begin
      sel = '{en: 1'b1, kind: prKind, ctrl: CTRL_W'(slot)};
    end else if (grp == G_APBX_PR) begin
      sel = '{en: 1'b1, kind: prKind, ctrl: CTRL_W'(APBX_BASE) + CTRL_W'(slot)};
    end
    return sel;
  endfunction

  cfgSel_t sDec, nsDec;
  logic    sWordOk, nsWordOk;

  assign sDec     = decode(1'b1, secAddr);
  assign nsDec    = decode(1'b0, nsAddr);
  assign sWordOk  = (secSize == SZ_WORD) && (secAddr[1:0] == 2'b00);
  assign nsWordOk = (nsSize == SZ_WORD) && (nsAddr[1:0] == 2'b00);

  always_comb begin
    strobe.sRd     = sDec;
    strobe.nsRd    = nsDec;
    strobe.sWr     = sDec;
    strobe.sWr.en  = sDec.en && secWrEn && sWordOk;
    strobe.nsWr    = nsDec;
    strobe.nsWr.en = nsDec.en && nsWrEn && nsWordOk;
  end

  // R6
  sec_wr_word_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sWr.en |-> (secSize == SZ_WORD && secAddr[1:0] == 2'b00 && secWrEn));

  // R6
  ns_wr_word_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nsWr.en |-> (nsSize == SZ_WORD && nsAddr[1:0] == 2'b00 && nsWrEn));

  // R5
  ns_wr_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nsWr.en |-> strobe.nsWr.kind == KIND_NSP);

endmodule

// File: rtl/ppc_cfg_dpath.sv
module ppc_cfg_dpath
  import ppc_cfg_pkg::*;
#(
  parameter int APB0_PORTS = 4,
  parameter int APB1_PORTS = 1,
  parameter int EXP_PORTS  = 16,
  parameter int MAX_PORTS  = 16,
  parameter int OUT_W      = NUM_CTRL * MAX_PORTS
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       strobe,
  input  logic [31:0]      sWdata,
  input  logic [31:0]      nsWdata,
  input  logic [1:0]       sLane,
  input  logic [1:0]       sSize,
  input  logic [1:0]       nsLane,
  input  logic [1:0]       nsSize,
  output logic [31:0]      sRdata,
  output logic [31:0]      nsRdata,
  output logic [OUT_W-1:0] portNonSec,
  output logic [OUT_W-1:0] portAccess
);

  typedef logic [NUM_CTRL-1:0][MAX_PORTS-1:0] maskBank_t;

  function automatic int ctrlPorts(input int c);
    if (c == 0) return APB0_PORTS;
    if (c == 1) return APB1_PORTS;
    return EXP_PORTS;
  endfunction

  function automatic logic [MAX_PORTS-1:0] portMask(input int n);
    logic [MAX_PORTS-1:0] m;
    for (int i = 0; i < MAX_PORTS; i++) m[i] = (i < n);
    return m;
  endfunction

  maskBank_t nsAll, spAll, nspAll;

  for (genvar c = 0; c < NUM_CTRL; c++) begin : ctrlGen
    localparam logic [MAX_PORTS-1:0] KEEP = portMask(ctrlPorts(c));
    logic [MAX_PORTS-1:0] nsQ, spQ, nspQ;
    logic                 sHit, nsHit;

    assign sHit  = strobe.sWr.en && (strobe.sWr.ctrl == CTRL_W'(c));
    assign nsHit = strobe.nsWr.en && (strobe.nsWr.kind == KIND_NSP) &&
                   (strobe.nsWr.ctrl == CTRL_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nsQ  <= '0;
        spQ  <= '0;
        nspQ <= '0;
      end else begin
        if (sHit && strobe.sWr.kind == KIND_NS) nsQ <= sWdata[MAX_PORTS-1:0] & KEEP;
        if (sHit && strobe.sWr.kind == KIND_SP) spQ <= sWdata[MAX_PORTS-1:0] & KEEP;
        if (nsHit) nspQ <= nsWdata[MAX_PORTS-1:0] & KEEP;
      end
    end

    assign nsAll[c]  = nsQ;
    assign spAll[c]  = spQ;
    assign nspAll[c] = nspQ;
    assign portNonSec[c*MAX_PORTS +: MAX_PORTS] = nsQ;
    assign portAccess[c*MAX_PORTS +: MAX_PORTS] = (nsQ & nspQ) | (~nsQ & spQ);
  end

  function automatic logic [31:0] pickWord(input cfgSel_t sel, input maskBank_t ns,
                                           input maskBank_t sp, input maskBank_t nsp);
    logic [31:0] w;
    w = '0;
    if (sel.en && int'(sel.ctrl) < NUM_CTRL) begin
      case (sel.kind)
        KIND_NS:  w[MAX_PORTS-1:0] = ns[sel.ctrl];
        KIND_SP:  w[MAX_PORTS-1:0] = sp[sel.ctrl];
        KIND_NSP: w[MAX_PORTS-1:0] = nsp[sel.ctrl];
        default:  w = '0;
      endcase
    end
    return w;
  endfunction

  function automatic logic [31:0] laneCut(input logic [31:0] w, input logic [1:0] lane,
                                          input logic [1:0] size);
    logic [31:0] s;
    s = w >> {lane, 3'b000};
    case (size)
      SZ_BYTE: return s & 32'h0000_00FF;
      SZ_HALF: return s & 32'h0000_FFFF;
      default: return w;
    endcase
  endfunction

  always_comb begin
    sRdata  = laneCut(pickWord(strobe.sRd, nsAll, spAll, nspAll), sLane, sSize);
    nsRdata = laneCut(pickWord(strobe.nsRd, nsAll, spAll, nspAll), nsLane, nsSize);
  end

  // R5
  ns_side_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sWr.en |=> ($stable(nsAll) && $stable(spAll)));

  // R5
  nsp_side_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.nsWr.en |=> $stable(nspAll));

  // R1
  access_follows_masks_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(nsAll) && $stable(spAll) && $stable(nspAll)) |-> $stable(portAccess));

  // R2
  nonsec_follows_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(nsAll) |-> $stable(portNonSec));

endmodule

// File: rtl/ppc_cfg_bank.sv
module ppc_cfg_bank
  import ppc_cfg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int APB0_PORTS = 4,
  parameter int APB1_PORTS = 1,
  parameter int EXP_PORTS  = 16,
  parameter int MAX_PORTS  = (EXP_PORTS > APB0_PORTS) ?
                             ((EXP_PORTS > APB1_PORTS) ? EXP_PORTS : APB1_PORTS) :
                             ((APB0_PORTS > APB1_PORTS) ? APB0_PORTS : APB1_PORTS),
  parameter int OUT_W      = NUM_CTRL * MAX_PORTS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secWrEn,
  input  logic [ADDR_W-1:0] secAddr,
  input  logic [1:0]        secSize,
  input  logic [31:0]       secWdata,
  output logic [31:0]       secRdata,
  input  logic              nsWrEn,
  input  logic [ADDR_W-1:0] nsAddr,
  input  logic [1:0]        nsSize,
  input  logic [31:0]       nsWdata,
  output logic [31:0]       nsRdata,
  output logic [OUT_W-1:0]  portNonSec,
  output logic [OUT_W-1:0]  portAccess
);

  cfgStrobe_t strobe;

  ppc_cfg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .secWrEn (secWrEn),
    .secAddr (secAddr),
    .secSize (secSize),
    .nsWrEn  (nsWrEn),
    .nsAddr  (nsAddr),
    .nsSize  (nsSize),
    .strobe  (strobe)
  );

  ppc_cfg_dpath #(
    .APB0_PORTS (APB0_PORTS),
    .APB1_PORTS (APB1_PORTS),
    .EXP_PORTS  (EXP_PORTS),
    .MAX_PORTS  (MAX_PORTS),
    .OUT_W      (OUT_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sWdata     (secWdata),
    .nsWdata    (nsWdata),
    .sLane      (secAddr[1:0]),
    .sSize      (secSize),
    .nsLane     (nsAddr[1:0]),
    .nsSize     (nsSize),
    .sRdata     (secRdata),
    .nsRdata    (nsRdata),
    .portNonSec (portNonSec),
    .portAccess (portAccess)
  );

  // R8
  sec_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secAddr[ADDR_W-1:2] == (ADDR_W-2)'(12'h050 >> 2) ||
     secAddr[ADDR_W-1:2] == (ADDR_W-2)'(12'h090 >> 2)) |-> secRdata == 32'h0);

  // R8
  ns_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nsAddr[ADDR_W-1:2] == (ADDR_W-2)'(12'h090 >> 2)) |-> nsRdata == 32'h0);

endmodule

// File: tb/ppc_cfg_bank_tb.sv
`timescale 1ns/100ps
module ppc_cfg_bank_tb_top;

  localparam int NC    = 10;
  localparam int MP    = 16;
  localparam int OW    = NC * MP;
  localparam real HALF = 2.5;
  localparam int  WATCHDOG_CYCLES = 150000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          secWrEn = 1'b0, nsWrEn = 1'b0;
  logic [11:0]   secAddr = '0, nsAddr = '0;
  logic [1:0]    secSize = 2'd2, nsSize = 2'd2;
  logic [31:0]   secWdata = '0, nsWdata = '0;
  logic [31:0]   secRdata, nsRdata;
  logic [OW-1:0] portNonSec, portAccess;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  logic [31:0] mNs[NC], mSp[NC], mNsp[NC];

  always #(HALF) clk = ~clk;

  ppc_cfg_bank dut_i (
    .clk(clk), .rstN(rstN),
    .secWrEn(secWrEn), .secAddr(secAddr), .secSize(secSize), .secWdata(secWdata),
    .secRdata(secRdata),
    .nsWrEn(nsWrEn), .nsAddr(nsAddr), .nsSize(nsSize), .nsWdata(nsWdata),
    .nsRdata(nsRdata),
    .portNonSec(portNonSec), .portAccess(portAccess)
  );

  function automatic int cports(input int c);
    return (c == 0) ? 4 : (c == 1) ? 1 : 16;
  endfunction

  // kind: 0 select, 1 secure-side access, 2 non-secure-side access; -1 none
  function automatic int mapIdx(input bit sec, input logic [11:0] a, output int kind);
    int off;
    off  = int'(a) & ~3;
    kind = -1;
    if (sec && (off == 'h70 || off == 'h74)) begin kind = 0; return (off - 'h70) / 4; end
    if (sec && off >= 'h80 && off <= 'h8C)   begin kind = 0; return 2 + (off - 'h80) / 4; end
    if (sec && off >= 'h60 && off <= 'h6C)   begin kind = 0; return 6 + (off - 'h60) / 4; end
    if (off == 'hB0 || off == 'hB4)          begin kind = sec ? 1 : 2; return (off - 'hB0) / 4; end
    if (off >= 'hC0 && off <= 'hCC)          begin kind = sec ? 1 : 2; return 2 + (off - 'hC0) / 4; end
    if (off >= 'hA0 && off <= 'hAC)          begin kind = sec ? 1 : 2; return 6 + (off - 'hA0) / 4; end
    return -1;
  endfunction

  function automatic logic [31:0] mRead(input bit sec, input logic [11:0] a, input logic [1:0] sz);
    int k, c;
    logic [31:0] w;
    w = '0;
    c = mapIdx(sec, a, k);
    if (c >= 0) w = (k == 0) ? mNs[c] : (k == 1) ? mSp[c] : mNsp[c];
    if (sz == 2'd0) return (w >> (int'(a[1:0]) * 8)) & 32'hFF;
    if (sz == 2'd1) return (w >> (int'(a[1:0]) * 8)) & 32'hFFFF;
    return w;
  endfunction

  function automatic void mWrite(input bit sec, input logic [11:0] a, input logic [1:0] sz,
                                 input logic [31:0] d);
    int k, c;
    logic [31:0] v;
    if (sz != 2'd2 || a[1:0] != 2'b00) return;
    c = mapIdx(sec, a, k);
    if (c < 0) return;
    v = d & ((32'h1 << cports(c)) - 32'h1);
    if (k == 0) mNs[c] = v;
    else if (k == 1) mSp[c] = v;
    else mNsp[c] = v;
  endfunction

  function automatic void mClear();
    for (int c = 0; c < NC; c++) begin mNs[c] = '0; mSp[c] = '0; mNsp[c] = '0; end
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [OW-1:0] act, input logic [OW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [OW-1:0] eNs, eAp;
    logic [31:0]   eS, eN;
    eNs = '0; eAp = '0;
    for (int c = 0; c < NC; c++)
      for (int p = 0; p < MP; p++) begin
        eNs[c*MP+p] = mNs[c][p];
        eAp[c*MP+p] = mNs[c][p] ? mNsp[c][p] : mSp[c][p];
      end
    eS = mRead(1'b1, secAddr, secSize);
    eN = mRead(1'b0, nsAddr, nsSize);
    chk(portNonSec === eNs, "R2", "portNonSec", portNonSec, eNs);
    chk(portAccess === eAp, "R1", "portAccess", portAccess, eAp);
    chk(secRdata === eS, tag, "secRdata", OW'(secRdata), OW'(eS));
    chk(nsRdata === eN, tag, "nsRdata", OW'(nsRdata), OW'(eN));
  endtask

  // one cycle: drive at falling edge, compare, then let the model take the edge
  task automatic step(input bit sw, input logic [11:0] sa, input logic [1:0] ssz,
                      input logic [31:0] sd, input bit nw, input logic [11:0] na,
                      input logic [1:0] nsz, input logic [31:0] nd, input string tag);
    @(negedge clk);
    secWrEn = sw; secAddr = sa; secSize = ssz; secWdata = sd;
    nsWrEn  = nw; nsAddr  = na; nsSize  = nsz; nsWdata  = nd;
    #1;
    compareAll(tag);
    @(posedge clk);
    if (rstN) begin
      if (sw) mWrite(1'b1, sa, ssz, sd);
      if (nw) mWrite(1'b0, na, nsz, nd);
    end
  endtask

  task automatic sWr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d,
                     input string tag);
    step(1'b1, a, sz, d, 1'b0, a, 2'd2, 32'h0, tag);
  endtask

  task automatic nWr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d,
                     input string tag);
    step(1'b0, a, 2'd2, 32'h0, 1'b1, a, sz, d, tag);
  endtask

  task automatic rd(input logic [11:0] sa, input logic [11:0] na, input logic [1:0] sz,
                    input string tag);
    step(1'b0, sa, sz, 32'h0, 1'b0, na, sz, 32'h0, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; secWrEn = 1'b0; nsWrEn = 1'b0;
    mClear();
    #1;
    compareAll("R9");
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [11:0] pool[26];
    int pi;
    pi = 0;
    for (int a = 'h60; a <= 'hCC; a += 4) pool[pi++ % 26] = 12'(a);
    pool[24] = 12'h050; pool[25] = 12'h000;

    mClear();
    rstN = 1'b0;
    #1;
    compareAll("R9");
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: everything reads zero after reset
    rd(12'h070, 12'h0B0, 2'd2, "R9");
    rd(12'h0C4, 12'h0A8, 2'd2, "R9");

    // R4 / R3: every secure select and secure-side mask, all ones
    for (int a = 'h60; a <= 'hCC; a += 4) sWr(12'(a), 2'd2, 32'hFFFF_FFFF, "R3");
    for (int a = 'h60; a <= 'hCC; a += 4) rd(12'(a), 12'(a), 2'd2, "R4");

    // R5: non-secure window sets non-secure-side masks with distinct values
    for (int a = 'hA0; a <= 'hCC; a += 4) nWr(12'(a), 2'd2, 32'h1234_0000 + 32'(a * 77), "R5");
    for (int a = 'hA0; a <= 'hCC; a += 4) rd(12'(a), 12'(a), 2'd2, "R5");

    // R5: non-secure window cannot touch selects; secure cannot touch non-secure side
    nWr(12'h070, 2'd2, 32'h0, "R5");
    nWr(12'h080, 2'd2, 32'h0, "R5");
    sWr(12'h0C0, 2'd2, 32'h0000_00A5, "R5");
    rd(12'h080, 12'h0C0, 2'd2, "R5");

    // R1: select pattern steers access between the two masks
    sWr(12'h080, 2'd2, 32'h0000_F0F0, "R1");
    sWr(12'h0C0, 2'd2, 32'h0000_3C3C, "R1");
    nWr(12'h0C0, 2'd2, 32'h0000_AAAA, "R1");
    rd(12'h080, 12'h0C0, 2'd2, "R1");
    sWr(12'h080, 2'd2, 32'h0000_0000, "R1");
    sWr(12'h080, 2'd2, 32'h0000_FFFF, "R1");

    // R6: byte, halfword and misaligned word writes are dropped
    sWr(12'h084, 2'd0, 32'h0000_0000, "R6");
    sWr(12'h084, 2'd1, 32'h0000_0000, "R6");
    sWr(12'h085, 2'd2, 32'h0000_0000, "R6");
    nWr(12'h0C4, 2'd0, 32'h0000_0000, "R6");
    rd(12'h084, 12'h0C4, 2'd2, "R6");

    // R7: sub-word reads on each lane
    sWr(12'h088, 2'd2, 32'h0000_C35A, "R7");
    for (int l = 0; l < 4; l++) rd(12'h088 + 12'(l), 12'h0C8 + 12'(l), 2'd0, "R7");
    for (int l = 0; l < 4; l++) rd(12'h088 + 12'(l), 12'h0C8 + 12'(l), 2'd1, "R7");

    // R8: reserved and unmapped offsets
    sWr(12'h050, 2'd2, 32'hFFFF_FFFF, "R8");
    sWr(12'h090, 2'd2, 32'hFFFF_FFFF, "R8");
    nWr(12'h090, 2'd2, 32'hFFFF_FFFF, "R8");
    nWr(12'h070, 2'd2, 32'hFFFF_FFFF, "R8");
    sWr(12'h078, 2'd2, 32'hFFFF_FFFF, "R8");
    sWr(12'h0B8, 2'd2, 32'hFFFF_FFFF, "R8");
    rd(12'h050, 12'h090, 2'd2, "R8");
    rd(12'h078, 12'h070, 2'd2, "R8");
    rd(12'h0B8, 12'h0B8, 2'd2, "R8");

    // R10: back-to-back writes, each compared in the following cycle
    for (int i = 0; i < 8; i++) sWr(12'h060 + 12'(4 * (i % 4)), 2'd2, 32'(i * 4369), "R10");

    // R9: reset in mid-run clears everything
    doReset();
    rd(12'h060, 12'h0A0, 2'd2, "R9");
    rd(12'h074, 12'h0B4, 2'd2, "R9");

    // mixed traffic on both windows
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] sa, na;
      sa = pool[$urandom_range(0, 25)] | 12'($urandom_range(0, 3) * ($urandom_range(0, 3) == 0));
      na = pool[$urandom_range(0, 25)] | 12'($urandom_range(0, 3) * ($urandom_range(0, 3) == 0));
      step(1'($urandom_range(0, 1)), sa, 2'($urandom_range(0, 2)), $urandom(),
           1'($urandom_range(0, 1)), na, 2'($urandom_range(0, 2)), $urandom(), "R4");
    end

    rd(12'h060, 12'h0A0, 2'd2, "R4");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule